// File: doc/BRIEF.md
# Command Slot Dispatcher

This block sits in front of a per-port command engine and decides which outstanding command slot the engine should take next. Software posts work by setting bits in a command-issue bitmap. The block only walks that bitmap while the port's start control is on. It offers one slot at a time to the engine, lowest number first, and holds each offer until the engine answers.

The engine answers in one of two ways. It can say the slot finished without leaving the device busy, and then the slot's issue bit is retired. It can also say the device is still busy, and then the slot is parked. A parked slot blocks all further offers until the device reports that the transfer has completed. At that point the parked slot is retired and a fresh walk starts from slot 0.

The block also mirrors the start and FIS-receive enables into two running-status outputs. The first time FIS reception is switched on after a port reset, it pulses a request for the initial device-to-host FIS.

Top module: `dsp_slot_dispatch`

## Requirements
- R1: After reset, `ci_bits` is 0, and `disp_req`, `busy_vld`, `list_run`, `fis_run` and `init_fis_req` are all 0.
- R2: A write on `ci_wr` ORs `ci_wdata` into `ci_bits` and never clears a bit. While the start enable is 0, no dispatch request is raised.
- R3: Slots are offered in ascending slot number, one at a time. `disp_req` stays high and `disp_slot` stays stable until `disp_ack` is seen. A walk is started by a write to the command register, a write to the issue bitmap, or a completion that retires a parked slot.
- R4: An acknowledge with `disp_left_busy` low clears that slot's bit in `ci_bits`.
- R5: If `dev_busy` is high when a slot is considered, that slot is not offered, the walk ends, and every issue bit is kept. A later trigger starts a new walk.
- R6: An acknowledge with `disp_left_busy` high keeps the issue bit, sets `busy_vld`, and shows the slot on `busy_slot`. No request is raised while `busy_vld` is high.
- R7: A `xfer_done` pulse with `dev_busy` low while a slot is parked clears that slot's issue bit and `busy_vld`, then walks again from slot 0. A `xfer_done` pulse while `dev_busy` is high changes nothing.
- R8: On a command write, `list_run` takes the value of `cmd_wdata[0]` (start) and `fis_run` takes the value of `cmd_wdata[1]` (FIS receive). Between command writes, both outputs hold.
- R9: `init_fis_req` pulses for exactly one cycle on the first command write with `cmd_wdata[1]` = 1 after a reset or port reset. Later such writes give no pulse until `port_rst` re-arms it.
- R10: `port_rst` drops any pending request, clears the parked slot, and ends the walk. It leaves `ci_bits` unchanged, and it does not start a new walk by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_rst | input | 1 | Synchronous port reset pulse |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 2 | Bit 0 start enable, bit 1 FIS receive enable |
| ci_wr | input | 1 | Issue bitmap write strobe |
| ci_wdata | input | NUM_SLOTS (32) | Bits to set in the issue bitmap |
| dev_busy | input | 1 | Device busy (BSY or DRQ) |
| xfer_done | input | 1 | Device completion event |
| disp_req | output | 1 | Dispatch request to the engine |
| disp_slot | output | SLOT_W (5) | Slot offered |
| disp_ack | input | 1 | Engine response strobe |
| disp_left_busy | input | 1 | With ack: device still busy after dispatch |
| ci_bits | output | NUM_SLOTS (32) | Current issue bitmap |
| list_run | output | 1 | List-running status |
| fis_run | output | 1 | FIS-running status |
| init_fis_req | output | 1 | One-cycle request for initial device-to-host FIS |
| busy_vld | output | 1 | A slot is parked |
| busy_slot | output | SLOT_W (5) | Parked slot number |

## Verification
The bench builds the block with `NUM_SLOTS` = 8. This allows every non-zero issue pattern, all 255 of them, to be posted and drained. The full dispatch order of each pattern is compared against the ascending list of its set bits. The small slot count also keeps each edge case short enough to check cycle by cycle: the parked highest slot, refusal while busy, a port reset during a pending offer, and the rescan after a completion.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_WAIT = 2'd2
  } dsp_state_e;

  localparam int CMD_W      = 2;
  localparam int CMDB_START = 0;
  localparam int CMDB_FISRX = 1;
endpackage

// File: rtl/dsp_slot_pick.sv
module dsp_slot_pick #(
  parameter int NUM_SLOTS = 32,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] bits,
  input  logic [SLOT_W-1:0]    floor_idx,
  output logic                 found,
  output logic [SLOT_W-1:0]    idx
);
  logic [NUM_SLOTS-1:0] masked;

  // keep only candidates at or above the walk pointer
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_mask
    assign masked[g] = bits[g] && (int'(floor_idx) <= g);
  end

  always_comb begin
    idx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (masked[i]) idx = SLOT_W'(i);
    end
  end

  assign found = |masked;
endmodule

// File: rtl/dsp_init_fis.sv
module dsp_init_fis (
  input  logic clk,
  input  logic rst_n,
  input  logic port_rst,
  input  logic cmd_wr,
  input  logic fis_rx,
  output logic init_req
);
  logic armed_q, armed_d, armed_en;
  logic req_q, req_d;

  always_comb begin
    armed_en = port_rst || (cmd_wr && fis_rx);
    armed_d  = port_rst;
    req_d    = !port_rst && cmd_wr && fis_rx && armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      req_q   <= 1'b0;
    end else begin
      if (armed_en) armed_q <= armed_d;
      req_q <= req_d;
    end
  end

  assign init_req = req_q;
endmodule

// File: rtl/dsp_slot_dispatch.sv
module dsp_slot_dispatch
  import dsp_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 port_rst,
  input  logic                 cmd_wr,
  input  logic [CMD_W-1:0]     cmd_wdata,
  input  logic                 ci_wr,
  input  logic [NUM_SLOTS-1:0] ci_wdata,
  input  logic                 dev_busy,
  input  logic                 xfer_done,
  output logic                 disp_req,
  output logic [SLOT_W-1:0]    disp_slot,
  input  logic                 disp_ack,
  input  logic                 disp_left_busy,
  output logic [NUM_SLOTS-1:0] ci_bits,
  output logic                 list_run,
  output logic                 fis_run,
  output logic                 init_fis_req,
  output logic                 busy_vld,
  output logic [SLOT_W-1:0]    busy_slot
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  dsp_state_e           st_q, st_d;
  logic [NUM_SLOTS-1:0] ci_q, ci_d, ci_clr;
  logic                 ci_en;
  logic                 start_q, fisrx_q;
  logic                 pend_q, pend_d;
  logic [SLOT_W-1:0]    ptr_q, ptr_d;
  logic [SLOT_W-1:0]    slot_q, slot_d;
  logic                 park_q, park_d;
  logic [SLOT_W-1:0]    park_slot_q;
  logic                 park_set;
  logic                 found;
  logic [SLOT_W-1:0]    pick_idx;
  logic                 complete, ack_ok, ack_done;

  dsp_slot_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
    .bits     (ci_q),
    .floor_idx(ptr_q),
    .found    (found),
    .idx      (pick_idx)
  );

  dsp_init_fis u_init (
    .clk     (clk),
    .rst_n   (rst_n),
    .port_rst(port_rst),
    .cmd_wr  (cmd_wr),
    .fis_rx  (cmd_wdata[CMDB_FISRX]),
    .init_req(init_fis_req)
  );

  always_comb begin
    complete = xfer_done && !dev_busy && park_q && !port_rst;
    ack_ok   = (st_q == ST_WAIT) && disp_ack && !port_rst;
    ack_done = ack_ok && !disp_left_busy;
    park_set = ack_ok && disp_left_busy;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      ci_clr[i] = (complete && park_slot_q == SLOT_W'(i)) ||
                  (ack_done && slot_q == SLOT_W'(i));
    end
    ci_en = ci_wr || (|ci_clr);
    ci_d  = (ci_q | (ci_wr ? ci_wdata : '0)) & ~ci_clr;
  end

  always_comb begin
    st_d   = st_q;
    ptr_d  = ptr_q;
    slot_d = slot_q;
    pend_d = pend_q;
    park_d = park_q;
    if (st_q == ST_IDLE) pend_d = 1'b0;
    if (cmd_wr || ci_wr || complete) pend_d = 1'b1;
    if (complete) park_d = 1'b0;
    if (park_set) park_d = 1'b1;
    unique case (st_q)
      ST_IDLE: begin
        if (pend_q && start_q && (|ci_q) && !park_q) begin
          st_d  = ST_SCAN;
          ptr_d = '0;
        end
      end
      ST_SCAN: begin
        if (!start_q || !found || dev_busy) begin
          st_d = ST_IDLE;
        end else begin
          st_d   = ST_WAIT;
          slot_d = pick_idx;
        end
      end
      ST_WAIT: begin
        if (disp_ack) begin
          if (disp_left_busy || slot_q == LAST_SLOT) begin
            st_d = ST_IDLE;
          end else begin
            st_d  = ST_SCAN;
            ptr_d = slot_q + SLOT_W'(1);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (port_rst) begin
      st_d   = ST_IDLE;
      pend_d = 1'b0;
      park_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      ci_q        <= '0;
      start_q     <= 1'b0;
      fisrx_q     <= 1'b0;
      pend_q      <= 1'b0;
      ptr_q       <= '0;
      slot_q      <= '0;
      park_q      <= 1'b0;
      park_slot_q <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      ptr_q  <= ptr_d;
      slot_q <= slot_d;
      park_q <= park_d;
      if (ci_en) ci_q <= ci_d;
      if (cmd_wr) begin
        start_q <= cmd_wdata[CMDB_START];
        fisrx_q <= cmd_wdata[CMDB_FISRX];
      end
      if (park_set) park_slot_q <= slot_q;
    end
  end

  assign disp_req  = (st_q == ST_WAIT);
  assign disp_slot = slot_q;
  assign ci_bits   = ci_q;
  assign list_run  = start_q;
  assign fis_run   = fisrx_q;
  assign busy_vld  = park_q;
  assign busy_slot = park_slot_q;
endmodule

// File: rtl/dsp_slot_dispatch_chk.sv
module dsp_slot_dispatch_chk #(
  parameter int NUM_SLOTS = 32,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 port_rst,
  input logic                 cmd_wr,
  input logic                 cmd_start,
  input logic                 disp_req,
  input logic [SLOT_W-1:0]    disp_slot,
  input logic                 disp_ack,
  input logic                 disp_left_busy,
  input logic [NUM_SLOTS-1:0] ci_bits,
  input logic                 list_run,
  input logic                 init_fis_req,
  input logic                 busy_vld
);
  logic [SLOT_W-1:0] seen_slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_slot_q <= '0;
    else        seen_slot_q <= disp_slot;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_req && !disp_ack && !port_rst) |=> (disp_req && $stable(disp_slot))); // R3

  AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_req && disp_ack && !disp_left_busy && !port_rst) |=> !ci_bits[seen_slot_q]); // R4

  AST_PARK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_vld |-> !disp_req); // R6

  AST_RUN_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (list_run == $past(cmd_start))); // R8

  AST_INIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    init_fis_req |=> !init_fis_req); // R9

  AST_PORT_RST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    port_rst |=> (!disp_req && !busy_vld)); // R10
endmodule

bind dsp_slot_dispatch dsp_slot_dispatch_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .port_rst      (port_rst),
  .cmd_wr        (cmd_wr),
  .cmd_start     (cmd_wdata[0]),
  .disp_req      (disp_req),
  .disp_slot     (disp_slot),
  .disp_ack      (disp_ack),
  .disp_left_busy(disp_left_busy),
  .ci_bits       (ci_bits),
  .list_run      (list_run),
  .init_fis_req  (init_fis_req),
  .busy_vld      (busy_vld)
);

// File: tb/tb_dsp_slot_dispatch.sv
module tb_dsp_slot_dispatch;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int SW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          port_rst = 1'b0;
  logic          cmd_wr = 1'b0;
  logic [1:0]    cmd_wdata = '0;
  logic          ci_wr = 1'b0;
  logic [N-1:0]  ci_wdata = '0;
  logic          dev_busy = 1'b0;
  logic          xfer_done = 1'b0;
  logic          disp_req;
  logic [SW-1:0] disp_slot;
  logic          disp_ack = 1'b0;
  logic          disp_left_busy = 1'b0;
  logic [N-1:0]  ci_bits;
  logic          list_run, fis_run, init_fis_req, busy_vld;
  logic [SW-1:0] busy_slot;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int init_cnt = 0;

  dsp_slot_dispatch #(.NUM_SLOTS(N)) dut (
    .clk(clk), .rst_n(rst_n), .port_rst(port_rst),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .ci_wr(ci_wr), .ci_wdata(ci_wdata),
    .dev_busy(dev_busy), .xfer_done(xfer_done),
    .disp_req(disp_req), .disp_slot(disp_slot),
    .disp_ack(disp_ack), .disp_left_busy(disp_left_busy),
    .ci_bits(ci_bits), .list_run(list_run), .fis_run(fis_run),
    .init_fis_req(init_fis_req), .busy_vld(busy_vld), .busy_slot(busy_slot)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && init_fis_req) init_cnt <= init_cnt + 1;
    if (cyc == 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ci_write(input logic [N-1:0] v);
    ci_wr = 1'b1; ci_wdata = v;
    tick();
    ci_wr = 1'b0; ci_wdata = '0;
  endtask

  task automatic cmd_write(input logic [1:0] v);
    cmd_wr = 1'b1; cmd_wdata = v;
    tick();
    cmd_wr = 1'b0; cmd_wdata = '0;
  endtask

  task automatic no_req(input string req, input int n);
    int seen = 0;
    for (int k = 0; k < n; k++) begin
      if (disp_req) seen = 1;
      tick();
    end
    chk(req, seen, 0);
  endtask

  // wait for an offer, check its slot, optionally stall, then answer
  task automatic serve(input string req, input int exp_slot, input logic lb, input int hold);
    int waited = 0;
    while (!disp_req && waited < 40) begin
      tick();
      waited++;
    end
    chk(req, disp_req ? longint'(disp_slot) : -1, exp_slot);
    for (int h = 0; h < hold; h++) begin
      tick();
      chk("R3", {disp_req, disp_slot}, {1'b1, SW'(exp_slot)});
    end
    disp_ack = 1'b1; disp_left_busy = lb;
    tick();
    disp_ack = 1'b0; disp_left_busy = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    // R1 reset values
    chk("R1", {ci_bits, disp_req, busy_vld, list_run, fis_run, init_fis_req}, 0);
    rst_n = 1'b1;
    tick();

    // R2: bits accumulate, no offer while start is off
    ci_write(8'h01);
    ci_write(8'h02);
    chk("R2", ci_bits, 8'h03);
    no_req("R2", 10);
    cmd_write(2'b01);
    chk("R8", {list_run, fis_run}, 2'b10);
    serve("R3", 0, 1'b0, 3);
    serve("R3", 1, 1'b0, 0);
    chk("R4", ci_bits, 0);

    // R3/R4 sweep of every non-zero pattern
    for (int p = 1; p < (1 << N); p++) begin
      ci_write(N'(p));
      for (int b = 0; b < N; b++) begin
        if (p[b]) serve("R3", b, 1'b0, 0);
      end
      chk("R4", ci_bits, 0);
      no_req("R3", 3);
    end

    // R6/R7: park, ignored completion while busy, real completion
    ci_write(8'h26);
    serve("R3", 1, 1'b1, 0);
    chk("R6", {busy_vld, busy_slot, ci_bits}, {1'b1, 3'd1, 8'h26});
    no_req("R6", 10);
    dev_busy = 1'b1; xfer_done = 1'b1;
    tick();
    xfer_done = 1'b0;
    tick();
    chk("R7", {busy_vld, ci_bits}, {1'b1, 8'h26});
    dev_busy = 1'b0; xfer_done = 1'b1;
    tick();
    xfer_done = 1'b0;
    chk("R7", {busy_vld, ci_bits}, {1'b0, 8'h24});
    serve("R7", 2, 1'b0, 0);
    serve("R7", 5, 1'b0, 0);
    chk("R7", ci_bits, 0);

    // R6: park the highest slot
    ci_write(8'h80);
    serve("R6", 7, 1'b1, 0);
    chk("R6", {busy_vld, busy_slot}, {1'b1, 3'd7});
    xfer_done = 1'b1;
    tick();
    xfer_done = 1'b0;
    chk("R7", {busy_vld, ci_bits}, {1'b0, 8'h00});
    no_req("R7", 5);

    // R5: refusal while device busy
    dev_busy = 1'b1;
    ci_write(8'h09);
    no_req("R5", 10);
    chk("R5", ci_bits, 8'h09);
    dev_busy = 1'b0;
    no_req("R5", 5);
    ci_write(8'h00);
    serve("R5", 0, 1'b0, 0);
    serve("R5", 3, 1'b0, 0);

    // R8: running bits follow enables
    cmd_write(2'b00);
    chk("R8", {list_run, fis_run}, 2'b00);
    ci_write(8'h04);
    no_req("R8", 5);
    // R9: initial FIS request
    cmd_write(2'b11);
    chk("R8", {list_run, fis_run}, 2'b11);
    tick();
    chk("R9", init_cnt, 1);
    serve("R3", 2, 1'b0, 0);
    cmd_write(2'b11);
    repeat (2) tick();
    chk("R9", init_cnt, 1);
    port_rst = 1'b1;
    tick();
    port_rst = 1'b0;
    cmd_write(2'b11);
    repeat (2) tick();
    chk("R9", init_cnt, 2);

    // R10: port reset during a pending offer and while parked
    ci_write(8'h10);
    repeat (4) tick();
    chk("R10", disp_req, 1);
    port_rst = 1'b1;
    tick();
    port_rst = 1'b0;
    chk("R10", {disp_req, ci_bits}, {1'b0, 8'h10});
    no_req("R10", 5);
    ci_write(8'h00);
    serve("R10", 4, 1'b0, 0);
    ci_write(8'h01);
    serve("R10", 0, 1'b1, 0);
    chk("R6", busy_vld, 1);
    port_rst = 1'b1;
    tick();
    port_rst = 1'b0;
    chk("R10", {busy_vld, ci_bits}, {1'b0, 8'h01});
    ci_write(8'h00);
    serve("R10", 0, 1'b0, 0);
    chk("R4", ci_bits, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule